// File: doc/BRIEF.md
# Conversion Threshold Monitor and Accumulator

This block watches the stream of 12-bit conversion results produced by a full read-all scan of a daisy chain of battery-monitor devices. Each result arrives with its 4-bit channel address. The address decides the class. Channels 0 to 5 are cell voltages. Channels 6 to 11 are auxiliary (temperature) inputs. Addresses 12 to 15 belong to neither class. The upper 8 bits of a result are compared with an 8-bit high/low threshold pair that belongs to the result's class. A sample may raise one alarm event, either rising or falling. The block also keeps a running sum of the cell-voltage results, which gives a pack-total figure.

Software opens each scan with a start pulse. The pulse carries the number of devices in the chain minus one. The block expects twelve results per device. It pulses `scan_done` once the last result of the scan has been accepted. Results form a valid/ready stream. Events leave through a one-entry valid/ready output. While an event waits to be taken, the input stream is held off. Thresholds are set through a simple write port.

Top module: `conv_alarm_monitor`

## Requirements
- R1: After reset, `ev_valid` and `scan_done` are 0, `sum_total` is 0 and `in_ready` is 1. Both high thresholds start at 0xFF and both low thresholds start at 0x00.
- R2: Address 0 to 5 is a cell result and address 6 to 11 is an auxiliary result. A result at address 12 to 15 raises no event and adds nothing to the sum, but it still takes a position in the scan.
- R3: Only `in_data[11:4]` is compared with the thresholds. If that value is greater than or equal to the class's high threshold, a rising event is raised. Otherwise, if it is less than or equal to the class's low threshold, a falling event is raised. No sample raises more than one event.
- R4: When `thr_we` is high, `thr_wdata` is written to the threshold chosen by `thr_sel`: 0 is the cell high threshold, 1 the cell low, 2 the aux high and 3 the aux low. The new value applies to samples accepted after the write edge.
- R5: `sum_total` is the sum of the cell results accepted in the current scan. It updates in the cycle after each accept. `scan_start` clears it to 0.
- R6: The scan length is (`dev_count`+1)*12 results. This length is captured at `scan_start`. `scan_done` is a one-cycle pulse in the cycle after the last result of the scan is accepted.
- R7: Results accepted before the first start, or after a scan has completed, raise no event and leave `sum_total` unchanged.
- R8: An event is visible in the cycle after its sample is accepted. `ev_aux` is 1 for the auxiliary class and 0 for the cell class. `ev_rise` is 1 for rising and 0 for falling. `ev_pos` is the 0-based position of the sample in the scan.
- R9: `in_ready` is low while `ev_valid` is high and `ev_ready` is low. Under this stall the event outputs hold their values, and a sample offered on the input is not taken.
- R10: If `scan_start` comes in the middle of a scan, the old scan is dropped. If a sample is accepted in the same cycle as `scan_start`, that sample is position 0 of the new scan and the first term of its sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Opens a new scan |
| dev_count | input | 3 | Devices in the chain minus one, sampled at start |
| in_valid | input | 1 | Result valid |
| in_ready | output | 1 | Result accepted when high with in_valid |
| in_addr | input | 4 | Channel address of the result |
| in_data | input | 12 | Conversion result |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold selector |
| thr_wdata | input | 8 | Threshold value |
| ev_valid | output | 1 | Event pending |
| ev_ready | input | 1 | Event consumer ready |
| ev_aux | output | 1 | Event class, 1 for auxiliary |
| ev_rise | output | 1 | Event direction, 1 for rising |
| ev_pos | output | 7 | Position of the sample in the scan |
| sum_total | output | 18 | Running cell-voltage sum |
| scan_done | output | 1 | Last result of the scan accepted |

## Verification
The assertions assume that `dev_count` matters only in the cycle with `scan_start`. They also assume that a stalled sample stays on the input until it is taken. They assume that nobody reads the event outputs while `ev_valid` is low. The bench drives every input on the falling edge. It holds `in_valid` and its payload while `in_ready` is low. It changes the thresholds only between samples, and it compares event fields only when an event is expected.

// File: rtl/conv_alarm_pkg.sv
package conv_alarm_pkg;
  // threshold selector codes; bit 1 picks the aux pair, bit 0 picks the low side
  typedef enum logic [1:0] {
    THR_CELL_HI = 2'd0,
    THR_CELL_LO = 2'd1,
    THR_AUX_HI  = 2'd2,
    THR_AUX_LO  = 2'd3
  } thr_sel_e;

  typedef enum logic [1:0] {
    CLS_CELL = 2'd0,
    CLS_AUX  = 2'd1,
    CLS_NONE = 2'd2
  } ch_class_e;
endpackage

// File: rtl/thr_bank.sv
module thr_bank #(
  parameter int THR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  thr_we,
  input  logic [1:0]            thr_sel,
  input  logic [THR_W-1:0]      thr_wdata,
  output logic [3:0][THR_W-1:0] thr_q
);
  logic [THR_W-1:0] regs [4];

  for (genvar g = 0; g < 4; g++) begin : g_thr
    // even codes are the high thresholds and reset fully open
    localparam logic [THR_W-1:0] RST_VAL = (g % 2 == 0) ? {THR_W{1'b1}} : {THR_W{1'b0}};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[g] <= RST_VAL;
      else if (thr_we && thr_sel == 2'(g))    regs[g] <= thr_wdata;
    end

    assign thr_q[g] = regs[g];

    // R4
    other_sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_we && thr_sel != 2'(g)) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import conv_alarm_pkg::*;
#(
  parameter int THR_W  = 8,
  parameter int ADDR_W = 4,
  parameter int CELLS  = 6,
  parameter int CHANS  = 12
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [THR_W-1:0]      level,
  input  logic [3:0][THR_W-1:0] thr_q,
  output logic                  hit,
  output logic                  is_aux,
  output logic                  is_cell,
  output logic                  rise
);
  ch_class_e        cls;
  logic [THR_W-1:0] hi_lim, lo_lim;
  logic             over, under;

  always_comb begin
    if (addr < ADDR_W'(CELLS))      cls = CLS_CELL;
    else if (addr < ADDR_W'(CHANS)) cls = CLS_AUX;
    else                            cls = CLS_NONE;
  end

  assign is_aux  = (cls == CLS_AUX);
  assign is_cell = (cls == CLS_CELL);
  assign hi_lim  = is_aux ? thr_q[THR_AUX_HI] : thr_q[THR_CELL_HI];
  assign lo_lim  = is_aux ? thr_q[THR_AUX_LO] : thr_q[THR_CELL_LO];
  assign over    = (level >= hi_lim);
  assign under   = (level <= lo_lim);
  // high test wins, so one event at most per sample
  assign rise    = over;
  assign hit     = (cls != CLS_NONE) && (over || under);
endmodule

// File: rtl/scan_track.sv
module scan_track #(
  parameter int DEV_W      = 3,
  parameter int POS_W      = 7,
  parameter int CH_PER_DEV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEV_W-1:0] dev_count,
  input  logic             accept,
  output logic             in_scan,
  output logic [POS_W-1:0] cur_pos,
  output logic             scan_done
);
  logic             active;
  logic [POS_W-1:0] pos, len_q, new_len;

  assign new_len = POS_W'((32'(dev_count) + 1) * CH_PER_DEV);
  assign in_scan = accept && (start || active);
  assign cur_pos = start ? '0 : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      pos       <= '0;
      len_q     <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (start) begin
        len_q  <= new_len;
        active <= 1'b1;
        pos    <= accept ? POS_W'(1) : '0;
      end else if (accept && active) begin
        pos <= pos + 1'b1;
        if (pos == len_q - 1'b1) begin
          active    <= 1'b0;
          scan_done <= 1'b1;
        end
      end
    end
  end

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pos < len_q));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
endmodule

// File: rtl/cell_accum.sv
module cell_accum #(
  parameter int DATA_W = 12,
  parameter int SUM_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_en,
  input  logic [DATA_W-1:0] value,
  output logic [SUM_W-1:0]  sum
);
  logic [SUM_W-1:0] base, addend;

  assign base   = clear  ? '0 : sum;
  assign addend = add_en ? SUM_W'(value) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum <= '0;
    else        sum <= base + addend;
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !add_en) |=> $stable(sum));
endmodule

// File: rtl/conv_alarm_monitor.sv
module conv_alarm_monitor #(
  parameter int DATA_W        = 12,
  parameter int THR_W         = 8,
  parameter int ADDR_W        = 4,
  parameter int CELLS_PER_DEV = 6,
  parameter int CH_PER_DEV    = 12,
  parameter int MAX_DEV       = 8,
  localparam int DEV_W        = $clog2(MAX_DEV),
  localparam int POS_W        = $clog2(MAX_DEV * CH_PER_DEV + 1),
  localparam int SUM_W        = DATA_W + $clog2(MAX_DEV * CELLS_PER_DEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic [DEV_W-1:0]  dev_count,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              thr_we,
  input  logic [1:0]        thr_sel,
  input  logic [THR_W-1:0]  thr_wdata,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic              ev_aux,
  output logic              ev_rise,
  output logic [POS_W-1:0]  ev_pos,
  output logic [SUM_W-1:0]  sum_total,
  output logic              scan_done
);
  logic [3:0][THR_W-1:0] thr_q;
  logic                  accept, in_scan, hit, is_aux, is_cell, rise;
  logic [POS_W-1:0]      cur_pos;

  assign in_ready = !ev_valid || ev_ready;
  assign accept   = in_valid && in_ready;

  thr_bank #(.THR_W(THR_W)) thr_i (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_sel(thr_sel),
    .thr_wdata(thr_wdata), .thr_q(thr_q)
  );

  alarm_cmp #(.THR_W(THR_W), .ADDR_W(ADDR_W), .CELLS(CELLS_PER_DEV), .CHANS(CH_PER_DEV)) cmp_i (
    .addr(in_addr), .level(in_data[DATA_W-1 -: THR_W]), .thr_q(thr_q),
    .hit(hit), .is_aux(is_aux), .is_cell(is_cell), .rise(rise)
  );

  scan_track #(.DEV_W(DEV_W), .POS_W(POS_W), .CH_PER_DEV(CH_PER_DEV)) trk_i (
    .clk(clk), .rst_n(rst_n), .start(scan_start), .dev_count(dev_count),
    .accept(accept), .in_scan(in_scan), .cur_pos(cur_pos), .scan_done(scan_done)
  );

  cell_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .clear(scan_start), .add_en(in_scan && is_cell),
    .value(in_data), .sum(sum_total)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_aux   <= 1'b0;
      ev_rise  <= 1'b0;
      ev_pos   <= '0;
    end else if (accept) begin
      ev_valid <= in_scan && hit;
      ev_aux   <= is_aux;
      ev_rise  <= rise;
      ev_pos   <= cur_pos;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  // R9
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_pos) && $stable(ev_aux) && $stable(ev_rise)));
  // R2
  aux_nosum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !scan_start && in_addr >= ADDR_W'(CELLS_PER_DEV)) |=> $stable(sum_total));
endmodule

// File: tb/conv_alarm_monitor_tb.sv
module conv_alarm_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic [2:0]  dev_count = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_addr = '0;
  logic [11:0] in_data = '0;
  logic        thr_we = 1'b0;
  logic [1:0]  thr_sel = '0;
  logic [7:0]  thr_wdata = '0;
  logic        ev_valid, ev_aux, ev_rise, scan_done;
  logic        ev_ready = 1'b1;
  logic [6:0]  ev_pos;
  logic [17:0] sum_total;

  int checks = 0;
  int errors = 0;
  int th [4];
  bit m_active = 0;
  int m_pos = 0, m_len = 0, m_sum = 0;

  always #5 clk = ~clk;

  conv_alarm_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .dev_count(dev_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_wdata(thr_wdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_aux(ev_aux), .ev_rise(ev_rise),
    .ev_pos(ev_pos), .sum_total(sum_total), .scan_done(scan_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_thr(input int sel, input int val);
    @(negedge clk);
    thr_we = 1'b1; thr_sel = 2'(sel); thr_wdata = 8'(val);
    @(negedge clk);
    thr_we = 1'b0;
    th[sel] = val;
  endtask

  task automatic begin_scan(input int dev, input string req);
    @(negedge clk);
    scan_start = 1'b1; dev_count = 3'(dev);
    @(negedge clk);
    scan_start = 1'b0;
    m_active = 1; m_pos = 0; m_len = (dev + 1) * 12; m_sum = 0;
    chk(sum_total == 0 && !scan_done, req, {sum_total, scan_done}, 0);
  endtask

  // sends one sample, then checks event, sum and done against the model
  task automatic send(input int a, input int d, input bit with_start, input int dev, input string req);
    bit e_ev, e_aux, e_rise, e_done;
    int e_pos, lvl;
    logic [28:0] act, exp;
    @(negedge clk);
    in_valid = 1'b1; in_addr = 4'(a); in_data = 12'(d);
    scan_start = with_start; dev_count = 3'(dev);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0; scan_start = 1'b0;
    if (with_start) begin
      m_active = 1; m_pos = 0; m_len = (dev + 1) * 12; m_sum = 0;
    end
    e_ev = 0; e_aux = 0; e_rise = 0; e_done = 0; e_pos = 0;
    if (m_active) begin
      lvl = d >> 4;
      e_pos = m_pos;
      if (a < 6) begin
        m_sum += d;
        if (lvl >= th[0]) begin e_ev = 1; e_rise = 1; end
        else if (lvl <= th[1]) e_ev = 1;
      end else if (a < 12) begin
        e_aux = 1;
        if (lvl >= th[2]) begin e_ev = 1; e_rise = 1; end
        else if (lvl <= th[3]) e_ev = 1;
      end
      m_pos++;
      if (m_pos == m_len) begin m_active = 0; e_done = 1; end
    end
    @(negedge clk);
    act = {ev_valid, ev_valid ? {ev_aux, ev_rise, ev_pos} : 9'd0, sum_total, scan_done};
    exp = {e_ev, e_ev ? {e_aux, e_rise, 7'(e_pos)} : 9'd0, 18'(m_sum), e_done};
    chk(act == exp, req, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    th[0] = 255; th[1] = 0; th[2] = 255; th[3] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ev_valid && !scan_done && sum_total == 0 && in_ready, "R1",
        {ev_valid, scan_done, sum_total, in_ready}, 1);
    // R7 before any start
    send(0, 'hFF0, 0, 0, "R7");
    send(8, 'hFFF, 0, 0, "R7");
    // R1 default thresholds: FF rises, 00 falls, middle quiet
    begin_scan(0, "R5");
    send(0, 'hFF0, 0, 0, "R1");
    send(1, 'h00F, 0, 0, "R1");
    send(2, 'h800, 0, 0, "R1");
    send(9, 'hFFF, 0, 0, "R1");
    send(10, 'h005, 0, 0, "R1");
    // R3 boundary: equal to high, equal to low, one inside each
    wr_thr(0, 'h80); wr_thr(1, 'h40); wr_thr(2, 'hA0); wr_thr(3, 'h20);
    send(3, 'h800, 0, 0, "R3");
    send(4, 'h7F0, 0, 0, "R3");
    send(5, 'h400, 0, 0, "R3");
    send(5, 'h410, 0, 0, "R3");
    send(6, 'hA0F, 0, 0, "R3");
    send(7, 'h200, 0, 0, "R3");
    send(11, 'h9FF, 0, 0, "R3");
    // R3 overlapping pair: high wins
    wr_thr(0, 'h30); wr_thr(1, 'h90);
    send(0, 'h500, 0, 0, "R3");
    send(0, 'h200, 0, 0, "R3");
    // R4 aux low write only changes aux low
    wr_thr(3, 'h70);
    send(7, 'h6FF, 0, 0, "R4");
    // R10 restart together with a sample
    send(2, 'h123, 1, 0, "R10");
    for (int i = 1; i < 12; i++) send(i % 12, 'h100 + i * 7, 0, 0, "R6");
    // R7 after done
    send(0, 'hFFF, 0, 0, "R7");
    send(1, 'h000, 0, 0, "R7");
    // sweep all chain lengths with varied thresholds and addresses
    for (int s = 0; s < 8; s++) begin
      wr_thr(0, 'h70 + s * 16); wr_thr(1, 'h10 + s * 8);
      wr_thr(2, 'h60 + s * 20); wr_thr(3, 'h08 + s * 12);
      begin_scan(s, "R5");
      for (int i = 0; i < (s + 1) * 12; i++) begin
        int a;
        a = (i % 7 == 6) ? 12 + (i % 4) : i % 12;
        send(a, (s * 977 + i * 211 + 5) % 4096, 0, 0, "R2/R6/R8");
      end
      @(negedge clk);
      chk(!scan_done, "R6", scan_done, 0);
    end
    // R10 mid-scan restart without sample
    begin_scan(2, "R10");
    send(0, 'h300, 0, 0, "R5");
    send(1, 'h300, 0, 0, "R5");
    begin_scan(0, "R10");
    // R9 back-pressure
    wr_thr(0, 'hC0); wr_thr(2, 'h90);
    ev_ready = 1'b0;
    send(0, 'hFF0, 0, 0, "R9");
    @(negedge clk);
    in_valid = 1'b1; in_addr = 4'd7; in_data = 12'hFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!in_ready && ev_valid && ev_pos == 0 && !ev_aux && ev_rise, "R9",
          {in_ready, ev_valid, ev_pos, ev_aux, ev_rise}, {1'b0, 1'b1, 7'd0, 1'b0, 1'b1});
    end
    ev_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(ev_valid && ev_aux && ev_rise && ev_pos == 1, "R9",
        {ev_valid, ev_aux, ev_rise, ev_pos}, {3'b111, 7'd1});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule